// File: doc/BRIEF.md
# DS3 Alarm and Idle Signature Detector

This block sits behind a DS3 framer that has already found frame alignment. It takes the received bit stream one qualified bit at a time. From the frame-start strobe it tracks where each bit falls inside the 4760-bit M-frame: 7 subframes, each of 8 blocks, each block one overhead bit followed by 84 payload bits. For every frame it decides whether the frame carries the alarm indication signature (AIS) and whether it carries the idle signature.

Each per-frame verdict feeds its own integration counter, which gives a hysteretic condition flag. A present frame adds to the active count and an absent frame leaves it alone. A run of absent frames as long as the threshold clears both the count and the flag. The threshold is selected with a 3-bit code that maps to 10 through 17 frames. The mode input tells the block whether the line uses C-bit parity framing or M23 framing; this changes only the idle test.

Top module: `ds3_ais_idle_det`

## Requirements
- R1: While reset is active and right after it is released, `frm_done`, `ais_frm`, `idle_frm`, `ais_det` and `idle_det` are 0.
- R2: Bit positions count only on cycles with `bit_vld` high. Position 0 follows reset. A valid bit with `frm_start` high is position 0 of a frame. `frm_done` is high for exactly the one cycle after the valid bit at position 4759 is taken.
- R3: The AIS overhead test uses the first overhead bit of each subframe, in subframe order: two X-bits, two P-bits, then three M-bits. In every subframe, blocks 1, 3, 5 and 7 hold the F-bits and blocks 2, 4 and 6 hold the C-bits. The test needs X=1, P=0, every C-bit 0, F-bits 1,0,0,1 in block order, and M-bits 0,1,0.
- R4: The AIS payload reference is 1,0,1,0,… and restarts with 1 on the first payload bit after each overhead bit. `ais_frm` goes high with `frm_done` when the R3 test passes and at most 7 payload bits differ from the reference. Eight differing bits give absent.
- R5: The idle overhead test needs X=1, valid F-bits and M-bits as in R3, and both P-bits equal to the XOR of all payload bits of the previous frame. That reference is 0 after reset.
- R6: The idle payload reference is 1,1,0,0,… and restarts with 1,1 after each overhead bit. `idle_frm` goes high with `frm_done` when the idle overhead test passes and at most 7 payload bits differ from the reference.
- R7: With `cbit_mode`=1, idle also needs the three C-bits of the third subframe to be 0. With `cbit_mode`=0, C-bits play no part in the idle test.
- R8: For each signature, a present frame adds one to its active count and clears its absent run. An absent frame leaves the active count unchanged. The flags change only in the cycle where `frm_done` is high.
- R9: A flag (`ais_det`, `idle_det`) is set at the end of the frame that brings its active count to the threshold, 10 + `thr_sel`.
- R10: After a number of consecutive absent frames equal to the threshold, the flag is cleared and the active count goes back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | `bit_in` holds a bit this cycle |
| frm_start | input | 1 | This valid bit is the first bit of an M-frame |
| cbit_mode | input | 1 | 1 = C-bit parity framing, 0 = M23 framing |
| thr_sel | input | 3 | Integration threshold code, threshold = 10 + code |
| frm_done | output | 1 | One-cycle pulse at the end of each frame |
| ais_frm | output | 1 | Frame just ended carried AIS (valid with `frm_done`) |
| idle_frm | output | 1 | Frame just ended carried idle (valid with `frm_done`) |
| ais_det | output | 1 | AIS condition declared |
| idle_det | output | 1 | Idle condition declared |

## Verification
The bound assertions check on every cycle that the frame pulse lasts one cycle and follows a valid bit, that verdicts appear only with it, and that the flags move only at frame ends. They also check that a flag rises only on a present frame and falls only on an absent one. Whether a given frame is judged correctly depends on where each bit sits in the frame. That includes the seven-versus-eight mismatch boundary, F-bit, C-bit and P-bit errors, mode-dependent C-bit handling, holding across absent frames and the exact frame of declaration and clearing. Only the bench's frame scenarios show these, checked against its behavioural model.

// File: rtl/ds3_ais_idle_det.sv
module ds3_ais_idle_det #(
  parameter int MISS_MAX = 7,
  parameter int THR_BASE = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_vld,
  input  logic       frm_start,
  input  logic       cbit_mode,
  input  logic [2:0] thr_sel,
  output logic       frm_done,
  output logic       ais_frm,
  output logic       idle_frm,
  output logic       ais_det,
  output logic       idle_det
);
  localparam int CNT_W = $clog2(MISS_MAX + 2);
  localparam int INT_W = $clog2(THR_BASE + 8 + 1);
  localparam logic [CNT_W-1:0] MISS_LIM = CNT_W'(MISS_MAX + 1);

  logic [2:0] sub_q, blk_q, s, b;
  logic [6:0] off_q, o, k;
  logic ais_bad_q, idle_bad_q, par_q, pref_q;
  logic [CNT_W-1:0] ais_cnt_q, idle_cnt_q, ais_cnt_b, idle_cnt_b, ais_cnt_n, idle_cnt_n;
  logic ais_bad_n, idle_bad_n, par_n;
  logic [1:0] pres;
  logic [INT_W-1:0] thr;

  assign s = frm_start ? 3'd0 : sub_q;
  assign b = frm_start ? 3'd0 : blk_q;
  assign o = frm_start ? 7'd0 : off_q;
  assign k = o - 7'd1;

  wire first = (s == 3'd0) && (b == 3'd0) && (o == 7'd0);
  wire last  = (s == 3'd6) && (b == 3'd7) && (o == 7'd84);
  wire oh    = (o == 7'd0);
  wire x_pos = oh && (b == 3'd0) && (s <= 3'd1);
  wire p_pos = oh && (b == 3'd0) && ((s == 3'd2) || (s == 3'd3));
  wire m_pos = oh && (b == 3'd0) && (s >= 3'd4);
  wire f_pos = oh && b[0];
  wire c_pos = oh && !b[0] && (b != 3'd0);

  wire fm_bad = (m_pos && (bit_in != (s == 3'd5))) ||
                (f_pos && (bit_in != ((b == 3'd1) || (b == 3'd7))));
  wire ais_oh_bad  = fm_bad || (x_pos && !bit_in) || ((p_pos || c_pos) && bit_in);
  wire idle_oh_bad = fm_bad || (x_pos && !bit_in) || (p_pos && (bit_in != pref_q)) ||
                     (cbit_mode && c_pos && (s == 3'd2) && bit_in);
  wire ais_miss  = !oh && (bit_in != o[0]);
  wire idle_miss = !oh && (bit_in != !k[1]);

  assign ais_bad_n  = (!first && ais_bad_q)  || ais_oh_bad;
  assign idle_bad_n = (!first && idle_bad_q) || idle_oh_bad;
  assign ais_cnt_b  = first ? '0 : ais_cnt_q;
  assign idle_cnt_b = first ? '0 : idle_cnt_q;
  assign ais_cnt_n  = (ais_miss  && ais_cnt_b  != MISS_LIM) ? ais_cnt_b  + 1'b1 : ais_cnt_b;
  assign idle_cnt_n = (idle_miss && idle_cnt_b != MISS_LIM) ? idle_cnt_b + 1'b1 : idle_cnt_b;
  assign par_n = (!first && par_q) ^ (!oh && bit_in);
  assign pres[0] = !ais_bad_n  && (ais_cnt_n  != MISS_LIM);
  assign pres[1] = !idle_bad_n && (idle_cnt_n != MISS_LIM);
  assign thr = INT_W'(THR_BASE) + INT_W'(thr_sel);

  wire frame_end = bit_vld && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0; blk_q <= '0; off_q <= '0;
      ais_bad_q <= 1'b0; idle_bad_q <= 1'b0;
      ais_cnt_q <= '0; idle_cnt_q <= '0;
      par_q <= 1'b0; pref_q <= 1'b0;
      frm_done <= 1'b0; ais_frm <= 1'b0; idle_frm <= 1'b0;
    end else begin
      frm_done <= frame_end;
      ais_frm  <= frame_end && pres[0];
      idle_frm <= frame_end && pres[1];
      if (bit_vld) begin
        off_q <= (o == 7'd84) ? 7'd0 : o + 7'd1;
        blk_q <= (o == 7'd84) ? b + 3'd1 : b;
        sub_q <= ((o == 7'd84) && (b == 3'd7)) ? ((s == 3'd6) ? 3'd0 : s + 3'd1) : s;
        ais_bad_q  <= ais_bad_n;
        idle_bad_q <= idle_bad_n;
        ais_cnt_q  <= ais_cnt_n;
        idle_cnt_q <= idle_cnt_n;
        par_q <= par_n;
        if (last) pref_q <= par_n;
      end
    end
  end

  logic [INT_W-1:0] act_q [2];
  logic [INT_W-1:0] abs_q [2];
  logic [1:0] det_q;

  for (genvar g = 0; g < 2; g++) begin : g_integ
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[g] <= '0; abs_q[g] <= '0; det_q[g] <= 1'b0;
      end else if (frame_end) begin
        if (pres[g]) begin
          abs_q[g] <= '0;
          if (act_q[g] + 1'b1 >= thr) begin
            act_q[g] <= thr;
            det_q[g] <= 1'b1;
          end else begin
            act_q[g] <= act_q[g] + 1'b1;
          end
        end else if (abs_q[g] + 1'b1 >= thr) begin
          act_q[g] <= '0; abs_q[g] <= '0; det_q[g] <= 1'b0;
        end else begin
          abs_q[g] <= abs_q[g] + 1'b1;
        end
      end
    end
  end

  assign ais_det  = det_q[0];
  assign idle_det = det_q[1];
endmodule

module ds3_ais_idle_det_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic frm_done,
  input logic ais_frm,
  input logic idle_frm,
  input logic ais_det,
  input logic idle_det
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);
  a_r2_done_after_vld: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(bit_vld));
  a_r4_verdict_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_frm || idle_frm) |-> frm_done);
  a_r8_flags_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |-> ($stable(ais_det) && $stable(idle_det)));
  a_r9_ais_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais_det) |-> ais_frm);
  a_r9_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_det) |-> idle_frm);
  a_r10_ais_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ais_det) |-> (frm_done && !ais_frm));
  a_r10_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_det) |-> (frm_done && !idle_frm));
endmodule

bind ds3_ais_idle_det ds3_ais_idle_det_chk u_chk (.*);

// File: tb/tb_ds3_ais_idle_det.sv
module tb_ds3_ais_idle_det;
  localparam int FLEN = 4760;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_in = 1'b0, bit_vld = 1'b0, frm_start = 1'b0, cbit_mode = 1'b1;
  logic [2:0] thr_sel = 3'd0;
  logic frm_done, ais_frm, idle_frm, ais_det, idle_det;

  int n_chk = 0, n_err = 0;
  bit fb [FLEN];
  bit mb [FLEN];
  bit gen_ppar = 0;
  int mpos = 0;
  bit mpref = 0;
  int m_act [2] = '{0, 0};
  int m_abs [2] = '{0, 0};
  bit e_done = 0, e_ais = 0, e_idle = 0;
  bit e_det [2] = '{0, 0};

  always #2 clk = ~clk;

  ds3_ais_idle_det dut (.*);

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  function automatic void model_eval();
    bit ab = 0, ib = 0, par = 0;
    int am = 0, im = 0;
    bit pr [2];
    for (int p = 0; p < FLEN; p++) begin
      int s = p / 680, b = (p % 680) / 85, o = p % 85;
      bit v = mb[p];
      if (o == 0) begin
        if (b == 0) begin
          if (s < 2) begin if (!v) begin ab = 1; ib = 1; end end
          else if (s < 4) begin if (v) ab = 1; if (v != mpref) ib = 1; end
          else if (v != (s == 5)) begin ab = 1; ib = 1; end
        end else if (b % 2 == 1) begin
          if (v != (b == 1 || b == 7)) begin ab = 1; ib = 1; end
        end else begin
          if (v) ab = 1;
          if (cbit_mode && s == 2 && v) ib = 1;
        end
      end else begin
        int k = o - 1;
        par ^= v;
        if (v != (k % 2 == 0)) am++;
        if (v != (k % 4 < 2)) im++;
      end
    end
    mpref = par;
    pr[0] = !ab && am <= 7;
    pr[1] = !ib && im <= 7;
    e_ais = pr[0];
    e_idle = pr[1];
    for (int g = 0; g < 2; g++) begin
      int thr = 10 + int'(thr_sel);
      if (pr[g]) begin
        m_abs[g] = 0;
        m_act[g] = (m_act[g] + 1 > thr) ? thr : m_act[g] + 1;
        if (m_act[g] >= thr) e_det[g] = 1;
      end else begin
        m_abs[g]++;
        if (m_abs[g] >= thr) begin m_act[g] = 0; m_abs[g] = 0; e_det[g] = 0; end
      end
    end
  endfunction

  task automatic compare_all();
    chk("R2 frm_done", frm_done, e_done);
    chk("R3/R4 ais_frm", ais_frm, e_ais);
    chk("R5/R6/R7 idle_frm", idle_frm, e_idle);
    chk("R8/R9/R10 ais_det", ais_det, e_det[0]);
    chk("R8/R9/R10 idle_det", idle_det, e_det[1]);
  endtask

  task automatic send_bit(bit v, bit fs);
    bit_in = v; bit_vld = 1'b1; frm_start = fs;
    if (fs) mpos = 0;
    mb[mpos] = v;
    @(posedge clk);
    e_done = 0; e_ais = 0; e_idle = 0;
    if (mpos == FLEN - 1) begin
      e_done = 1;
      model_eval();
    end
    mpos = (mpos == FLEN - 1) ? 0 : mpos + 1;
    @(negedge clk);
    compare_all();
  endtask

  task automatic gap();
    bit_vld = 1'b0; frm_start = 1'b0; bit_in = 1'b1;
    @(posedge clk);
    e_done = 0; e_ais = 0; e_idle = 0;
    @(negedge clk);
    compare_all();
  endtask

  // kind 0 = AIS, 1 = idle
  task automatic build_frame(int kind, int nflip, int flip_pos);
    bit par = 0;
    for (int p = 0; p < FLEN; p++) begin
      int s = p / 680, b = (p % 680) / 85, o = p % 85;
      bit v;
      if (o == 0) begin
        if (b == 0) begin
          case (s)
            0, 1: v = 1;
            2, 3: v = (kind == 0) ? 1'b0 : gen_ppar;
            5: v = 1;
            default: v = 0;
          endcase
        end else if (b % 2 == 1) v = (b == 1 || b == 7);
        else v = 0;
      end else begin
        int k = o - 1;
        v = (kind == 0) ? (k % 2 == 0) : (k % 4 < 2);
      end
      fb[p] = v;
    end
    for (int i = 0; i < nflip; i++) fb[85 * i + 1] ^= 1'b1;
    if (flip_pos >= 0) fb[flip_pos] ^= 1'b1;
    for (int p = 0; p < FLEN; p++) if (p % 85 != 0) par ^= fb[p];
    gen_ppar = par;
  endtask

  task automatic send_frame(int kind, int nflip, int flip_pos);
    build_frame(kind, nflip, flip_pos);
    for (int p = 0; p < FLEN; p++) begin
      if (p % 500 == 250) gap();
      send_bit(fb[p], p == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 frm_done in reset", frm_done, 1'b0);
    chk("R1 ais_det in reset", ais_det, 1'b0);
    chk("R1 idle_det in reset", idle_det, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    chk("R1 ais_frm after reset", ais_frm, 1'b0);
    chk("R1 idle_frm after reset", idle_frm, 1'b0);

    // R2: partial stream without frame start, then resync
    for (int i = 0; i < 300; i++) send_bit(1'b0, 1'b0);

    send_frame(0, 7, -1);
    chk("R4 seven payload misses still AIS", ais_frm, 1'b1);
    chk("R2 frame pulse after 4760 bits", frm_done, 1'b1);
    send_frame(0, 8, -1);
    chk("R4 eight payload misses not AIS", ais_frm, 1'b0);
    send_frame(0, 0, 85);
    chk("R3 bad F1 rejects AIS", ais_frm, 1'b0);
    send_frame(0, 0, 1530);
    chk("R3 C-bit set rejects AIS", ais_frm, 1'b0);
    for (int f = 0; f < 8; f++) send_frame(0, 0, -1);
    chk("R8 nine present frames hold below threshold", ais_det, 1'b0);
    send_frame(0, 0, -1);
    chk("R9 AIS declared on tenth present frame", ais_det, 1'b1);

    send_frame(1, 0, 1360);
    chk("R5 wrong P1 rejects idle", idle_frm, 1'b0);
    send_frame(1, 7, -1);
    chk("R6 seven misses still idle", idle_frm, 1'b1);
    send_frame(1, 8, -1);
    chk("R6 eight misses not idle", idle_frm, 1'b0);
    cbit_mode = 1'b0;
    send_frame(1, 0, 1530);
    chk("R7 M23 ignores C31", idle_frm, 1'b1);
    cbit_mode = 1'b1;
    send_frame(1, 0, 1530);
    chk("R7 C-bit mode needs C31 zero", idle_frm, 1'b0);
    for (int f = 0; f < 4; f++) send_frame(1, 0, -1);
    chk("R10 AIS held after nine absent frames", ais_det, 1'b1);
    send_frame(1, 0, -1);
    chk("R10 AIS cleared on tenth absent frame", ais_det, 1'b0);
    for (int f = 0; f < 2; f++) send_frame(1, 0, -1);
    chk("R8 idle count held across absent frames", idle_det, 1'b0);
    send_frame(1, 0, -1);
    chk("R9 idle declared on tenth present frame", idle_det, 1'b1);

    finish_run();
  end
endmodule